// File: doc/BRIEF.md
# Exception Masking Gate

This block decides whether the exception currently pending at a processor core may be taken now, or must wait. It holds three masking registers: a one-bit global mask that still lets the nonmaskable interrupt and the hard fault through, a one-bit stricter mask that lets only the nonmaskable interrupt through, and a priority threshold register whose compare is switched off when it holds zero.

The pending exception arrives as a number (zero meaning nothing is pending), a priority value (lower number means more urgent), and two flags that mark it as the nonmaskable interrupt or the hard fault. The decision is combinational from these inputs and the current register contents. Each register has its own write enable and data port, and a write is visible from the following rising clock edge. Choosing among several pending exceptions is done upstream; this block only gates the winner.

Top module: `excmask_top`

## Requirements
- R1: When the exception number is zero, `take` is 0 whatever the other inputs and masks are.
- R2: A pending exception with `exc_is_nmi` = 1 always gives `take` = 1, for every mask setting and priority.
- R3: With the global mask set (1) and the strict mask clear, a pending hard fault (`exc_is_hf` = 1, `exc_is_nmi` = 0) is taken and every exception that is neither hard fault nor NMI is blocked.
- R4: With the strict mask set (1), every pending exception that is not the NMI is blocked, hard fault included.
- R5: With both one-bit masks clear and the threshold nonzero, an exception that is neither NMI nor hard fault is blocked exactly when its priority value is numerically greater than or equal to the threshold; a hard fault is taken regardless of the threshold.
- R6: A threshold of zero blocks nothing: with both one-bit masks clear, every pending exception is taken at every priority value.
- R7: A synchronous active-high reset clears all three registers, so after reset every pending exception is taken.
- R8: A register changes only on a rising edge with its write enable at 1; the decision in the cycle of the write still uses the old value, and data presented with the enable at 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exc_num | input | NUM_W | Pending exception number, 0 = none pending |
| exc_prio | input | PRIO_W | Priority value of the pending exception, lower = more urgent |
| exc_is_nmi | input | 1 | Pending exception is the nonmaskable interrupt |
| exc_is_hf | input | 1 | Pending exception is the hard fault |
| gm_we | input | 1 | Write enable for the global mask bit |
| gm_wd | input | 1 | Write data for the global mask bit |
| sm_we | input | 1 | Write enable for the strict mask bit |
| sm_wd | input | 1 | Write data for the strict mask bit |
| thr_we | input | 1 | Write enable for the priority threshold |
| thr_wd | input | PRIO_W | Write data for the priority threshold |
| take | output | 1 | 1 = the pending exception may be taken now |

## Verification
The bench builds the block with PRIO_W = 3 and NUM_W = 4, which makes the threshold and the priority each take only eight values. That puts every combination of the two mask bits, all eight thresholds, all sixteen exception numbers, all eight priorities and all four flag pairs within reach, so each equal, below and above case of the threshold compare and every overlap between masks is visited. Separate sequences probe the write timing: the cycle before a write lands, and data presented with the enable held low.

// File: rtl/excmask_pkg.sv
package excmask_pkg;

  // Which rule settled the decision, in order of precedence.
  typedef enum logic [2:0] {
    V_IDLE      = 3'd0,  // nothing pending
    V_NMI       = 3'd1,  // nonmaskable, always admitted
    V_STRICT    = 3'd2,  // strict mask blocks
    V_HARDFAULT = 3'd3,  // hard fault admitted past global mask and threshold
    V_GLOBAL    = 3'd4,  // global mask blocks
    V_THRESH    = 3'd5,  // threshold blocks
    V_OPEN      = 3'd6   // no rule blocks
  } verdict_e;

  function automatic logic verdict_admits(verdict_e v);
    return (v == V_NMI) || (v == V_HARDFAULT) || (v == V_OPEN);
  endfunction

endpackage

// File: rtl/excmask_reg.sv
module excmask_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wd;
  end

endmodule

// File: rtl/excmask_thresh.sv
module excmask_thresh #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0] level,
  output logic              blocked
);

  localparam logic [PRIO_W-1:0] OFF = '0;

  logic armed;

  always_comb begin
    armed   = (level != OFF);
    blocked = armed && (prio >= level);
  end

endmodule

// File: rtl/excmask_decide.sv
module excmask_decide
  import excmask_pkg::*;
(
  input  logic     pending,
  input  logic     is_nmi,
  input  logic     is_hf,
  input  logic     gmask,
  input  logic     smask,
  input  logic     thr_blk,
  output verdict_e verdict
);

  always_comb begin
    if (!pending)     verdict = V_IDLE;
    else if (is_nmi)  verdict = V_NMI;
    else if (smask)   verdict = V_STRICT;
    else if (is_hf)   verdict = V_HARDFAULT;
    else if (gmask)   verdict = V_GLOBAL;
    else if (thr_blk) verdict = V_THRESH;
    else              verdict = V_OPEN;
  end

endmodule

// File: rtl/excmask_top.sv
module excmask_top
  import excmask_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int NUM_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_W-1:0]  exc_num,
  input  logic [PRIO_W-1:0] exc_prio,
  input  logic              exc_is_nmi,
  input  logic              exc_is_hf,
  input  logic              gm_we,
  input  logic              gm_wd,
  input  logic              sm_we,
  input  logic              sm_wd,
  input  logic              thr_we,
  input  logic [PRIO_W-1:0] thr_wd,
  output logic              take
);

  localparam int MASK_BITS = 2;

  logic [MASK_BITS-1:0] bit_we, bit_wd, bit_q;
  logic                 gm_q, sm_q;
  logic [PRIO_W-1:0]    thr_q;
  logic                 thr_blk;
  logic                 pending;
  verdict_e             verdict;

  assign bit_we = {sm_we, gm_we};
  assign bit_wd = {sm_wd, gm_wd};

  for (genvar i = 0; i < MASK_BITS; i++) begin : g_bit
    excmask_reg #(.W(1)) u_bit (
      .clk (clk),
      .rst (rst),
      .we  (bit_we[i]),
      .wd  (bit_wd[i]),
      .q   (bit_q[i])
    );
  end

  assign gm_q = bit_q[0];
  assign sm_q = bit_q[1];

  excmask_reg #(.W(PRIO_W)) u_thr (
    .clk (clk),
    .rst (rst),
    .we  (thr_we),
    .wd  (thr_wd),
    .q   (thr_q)
  );

  excmask_thresh #(.PRIO_W(PRIO_W)) u_cmp (
    .prio    (exc_prio),
    .level   (thr_q),
    .blocked (thr_blk)
  );

  assign pending = |exc_num;

  excmask_decide u_dec (
    .pending (pending),
    .is_nmi  (exc_is_nmi),
    .is_hf   (exc_is_hf),
    .gmask   (gm_q),
    .smask   (sm_q),
    .thr_blk (thr_blk),
    .verdict (verdict)
  );

  assign take = verdict_admits(verdict);

endmodule

// File: rtl/excmask_chk.sv
module excmask_chk #(
  parameter int PRIO_W = 8,
  parameter int NUM_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_W-1:0]  exc_num,
  input logic [PRIO_W-1:0] exc_prio,
  input logic              exc_is_nmi,
  input logic              exc_is_hf,
  input logic              gm_we,
  input logic              sm_we,
  input logic              thr_we,
  input logic              gm_q,
  input logic              sm_q,
  input logic [PRIO_W-1:0] thr_q,
  input logic              take
);

  // R1
  idle_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_num == '0) |-> !take);

  // R2
  nmi_admit_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_num != '0 && exc_is_nmi) |-> take);

  // R4
  strict_block_chk: assert property (@(posedge clk) disable iff (rst)
    (sm_q && !exc_is_nmi) |-> !take);

  // R3
  global_block_chk: assert property (@(posedge clk) disable iff (rst)
    (gm_q && !exc_is_nmi && !exc_is_hf) |-> !take);

  // R5
  thresh_block_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_q != '0 && exc_prio >= thr_q && !exc_is_nmi && !exc_is_hf) |-> !take);

  // R6
  open_admit_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_num != '0 && !gm_q && !sm_q && thr_q == '0) |-> take);

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!gm_q && !sm_q && thr_q == '0));

  // R8
  hold_gm_chk: assert property (@(posedge clk) disable iff (rst)
    !gm_we |=> $stable(gm_q));

  // R8
  hold_thr_chk: assert property (@(posedge clk) disable iff (rst)
    !thr_we |=> $stable(thr_q));

  // R8
  hold_sm_chk: assert property (@(posedge clk) disable iff (rst)
    !sm_we |=> $stable(sm_q));

endmodule

bind excmask_top excmask_chk #(.PRIO_W(PRIO_W), .NUM_W(NUM_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .exc_num    (exc_num),
  .exc_prio   (exc_prio),
  .exc_is_nmi (exc_is_nmi),
  .exc_is_hf  (exc_is_hf),
  .gm_we      (gm_we),
  .sm_we      (sm_we),
  .thr_we     (thr_we),
  .gm_q       (gm_q),
  .sm_q       (sm_q),
  .thr_q      (thr_q),
  .take       (take)
);

// File: tb/sim_excmask_top.sv
module sim_excmask_top;

  localparam int PW = 3;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] exc_num = '0;
  logic [PW-1:0] exc_prio = '0;
  logic          exc_is_nmi = 1'b0;
  logic          exc_is_hf = 1'b0;
  logic          gm_we = 1'b0, gm_wd = 1'b0;
  logic          sm_we = 1'b0, sm_wd = 1'b0;
  logic          thr_we = 1'b0;
  logic [PW-1:0] thr_wd = '0;
  logic          take;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  excmask_top #(.PRIO_W(PW), .NUM_W(NW)) u0 (
    .clk(clk), .rst(rst),
    .exc_num(exc_num), .exc_prio(exc_prio),
    .exc_is_nmi(exc_is_nmi), .exc_is_hf(exc_is_hf),
    .gm_we(gm_we), .gm_wd(gm_wd),
    .sm_we(sm_we), .sm_wd(sm_wd),
    .thr_we(thr_we), .thr_wd(thr_wd),
    .take(take)
  );

  function automatic logic model(int num, int prio, bit nmi, bit hf,
                                 bit gm, bit sm, int thr);
    if (num == 0) return 1'b0;
    if (nmi)      return 1'b1;
    if (sm)       return 1'b0;
    if (hf)       return 1'b1;
    if (gm)       return 1'b0;
    if (thr != 0 && prio >= thr) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string tag_of(int num, bit nmi, bit gm, bit sm, int thr);
    if (num == 0) return "R1";
    if (nmi)      return "R2";
    if (sm)       return "R4";
    if (gm)       return "R3";
    if (thr != 0) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: take=%b expected %b (num=%0d prio=%0d nmi=%b hf=%b)",
               req, got, exp, exc_num, exc_prio, exc_is_nmi, exc_is_hf);
    end
  endtask

  task automatic set_exc(int num, int prio, bit nmi, bit hf);
    exc_num = NW'(num); exc_prio = PW'(prio);
    exc_is_nmi = nmi; exc_is_hf = hf;
    #1;
  endtask

  task automatic write_all(bit gm, bit sm, int thr);
    @(negedge clk);
    gm_we = 1; gm_wd = gm; sm_we = 1; sm_wd = sm;
    thr_we = 1; thr_wd = PW'(thr);
    @(negedge clk);
    gm_we = 0; sm_we = 0; thr_we = 0;
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R7: after reset, no mask active
    for (int p = 0; p < 8; p++) begin
      set_exc(5, p, 0, 0);
      check("R7", take, 1'b1);
    end

    // Exhaustive sweep of masks, thresholds and exception attributes
    for (int cfg = 0; cfg < 32; cfg++) begin
      bit gm = cfg[0];
      bit sm = cfg[1];
      int thr = cfg >> 2;
      write_all(gm, sm, thr);
      for (int n = 0; n < 16; n++)
        for (int p = 0; p < 8; p++)
          for (int f = 0; f < 4; f++) begin
            set_exc(n, p, f[0], f[1]);
            check(tag_of(n, f[0], gm, sm, thr), take,
                  model(n, p, f[0], f[1], gm, sm, thr));
          end
    end

    // R8: write lands only at the edge
    write_all(0, 0, 0);
    @(negedge clk);
    set_exc(3, 5, 0, 0);
    thr_we = 1; thr_wd = 3'd2;
    #1; check("R8", take, 1'b1);   // old threshold still in effect
    @(negedge clk);
    thr_we = 0;
    #1; check("R8", take, 1'b0);   // 5 >= 2 now blocks

    // R8: data with enable low is ignored
    thr_wd = 3'd0; gm_wd = 1; sm_wd = 1;
    @(negedge clk); @(negedge clk);
    set_exc(3, 1, 0, 0);
    #1; check("R8", take, 1'b1);   // 1 < 2, masks untouched
    set_exc(3, 6, 0, 1);
    check("R8", take, 1'b1);       // hard fault, strict mask not written
    set_exc(3, 6, 0, 0);
    check("R8", take, 1'b0);       // threshold 2 still held

    // R7: reset mid-run clears masks
    write_all(1, 1, 7);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    set_exc(9, 7, 0, 0);
    check("R7", take, 1'b1);

    report();
  end

endmodule